// File: doc/BRIEF.md
# NOR-Branch Microcode Sequencer

This block is the control sequencer of a very small processor whose only arithmetic operation is an 8-bit bitwise NOR. A free-running divide-by-two phase splits every micro-step into two base-clock cycles. The first is a setup cycle in which the control word is presented. The second is a pulse cycle in which write enables fire. The step counter advances at the end of the pulse cycle. One step counter addresses two internal microcode tables at once. The first table holds the write-enable word. The second holds the output-enable and miscellaneous control word.

An embedded NOR unit holds two operand registers that are loaded from the data bus under microcode control. It can place its result on the bus through an enable. It also keeps a registered all-zero flag that forms the top address bit of the second table, so each step has two alternative control words. This gives the microprogram a conditional branch. A microcode bit ends the instruction by clearing the step counter. Both tables are filled through a write-only load port, normally while reset is held.

Top module: `nor_useq`

## Requirements
- R1: The phase alternates strictly every clock: setup, then pulse. `we_o` is zero in every setup cycle and can be nonzero only in the pulse cycle, which is the second cycle of each step.
- R2: During a step, `oe_o` in both cycles equals second-table entry {flag, step}, where address bit STEP_W is the flag. `we_o` in the pulse cycle equals first-table entry `step`.
- R3: If bit 0 of the current control word is set, the next step is 0. Otherwise the step counter increments at the end of the pulse cycle.
- R4: Control bit 1 loads operand A from `bus_i` at the end of the pulse cycle. Control bit 2 loads operand B in the same way.
- R5: While control bit 3 is set, `bus_oe_o` is 1 and `bus_o` is the bitwise NOR of A and B. Otherwise `bus_oe_o` is 0 and `bus_o` is 0.
- R6: The flag becomes 1 only when all eight NOR result bits are 0.
- R7: The flag is captured at the end of each step from the operands held during that step. An operand loaded in step k therefore first steers the table address in step k+2.
- R8: While `rst_i` is high, `we_o`, `oe_o`, `bus_o` and `bus_oe_o` are all 0. The first cycle after release is the setup cycle of step 0, with both operands and the flag cleared.
- R9: `ld_we_tbl_i` writes `ld_data_i` into first-table entry `ld_addr_i[STEP_W-1:0]`. `ld_oe_tbl_i` writes it into second-table entry `ld_addr_i`. Other entries keep their contents.
- R10: When the last step, 2^STEP_W-1, ends without the end bit set, the counter wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ld_we_tbl_i | input | 1 | Write strobe for the write-enable table |
| ld_oe_tbl_i | input | 1 | Write strobe for the control table |
| ld_addr_i | input | STEP_W+1 | Table entry address; top bit selects the flag half |
| ld_data_i | input | max(WE_W,OE_W) | Table entry data |
| bus_i | input | DATA_W | Data bus value seen by the operand registers |
| we_o | output | WE_W | Write enables, pulse cycle only |
| oe_o | output | OE_W | Output-enable and miscellaneous control word |
| bus_o | output | DATA_W | NOR result, zero when detached |
| bus_oe_o | output | 1 | Drive enable for `bus_o` |

## Verification
A wrong step count or phase shows at once in `oe_o`, because every table entry carries a step-specific tag. It also shows in `we_o`, which would be nonzero in a setup cycle or would carry the wrong tag. A corrupted operand register appears on `bus_o` at the next drive step. A flag that is mis-sampled or sampled a step early selects the wrong table half, so `oe_o` is wrong in the first affected step. The branch steps are arranged so that an early flag and a late flag each give a different tag from the correct one.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic {PH_SETUP = 1'b0, PH_PULSE = 1'b1} useq_phase_e;
   localparam int CB_END  = 0;
   localparam int CB_LDA  = 1;
   localparam int CB_LDB  = 2;
   localparam int CB_DRV  = 3;
   localparam int CB_MINW = 4;
endpackage

// File: rtl/useq_phase.sv
module useq_phase
   import useq_pkg::*;
#(
   parameter int STEP_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              end_i,
   output useq_phase_e       phase_o,
   output logic [STEP_W-1:0] step_o
);
   localparam logic [STEP_W-1:0] STEP_ONE = 1;

   useq_phase_e       phase_q;
   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_SETUP;
         step_q  <= '0;
      end else begin
         phase_q <= (phase_q == PH_SETUP) ? PH_PULSE : PH_SETUP;
         if (phase_q == PH_PULSE) begin
            step_q <= end_i ? '0 : step_q + STEP_ONE;
         end
      end
   end

   assign phase_o = phase_q;
   assign step_o  = step_q;
endmodule

// File: rtl/useq_table.sv
module useq_table #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("useq_table: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("useq_table: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         mem_q[wr_addr_i] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/useq_nor.sv
module useq_nor #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_a_i,
   input  logic              ld_b_i,
   input  logic              smp_i,
   input  logic              drv_i,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe_o,
   output logic              zflag_o
);
   logic [DATA_W-1:0] opa_q, opb_q, res;
   logic              zflag_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         opa_q   <= '0;
         opb_q   <= '0;
         zflag_q <= 1'b0;
      end else begin
         if (ld_a_i) opa_q <= bus_i;
         if (ld_b_i) opb_q <= bus_i;
         if (smp_i)  zflag_q <= ~|res;
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_gate
      assign res[b] = ~(opa_q[b] | opb_q[b]);
   end

   assign bus_o    = drv_i ? res : '0;
   assign bus_oe_o = drv_i;
   assign zflag_o  = zflag_q;
endmodule

// File: rtl/nor_useq.sv
module nor_useq
   import useq_pkg::*;
#(
   parameter int STEP_W = 4,
   parameter int WE_W   = 8,
   parameter int OE_W   = 8,
   parameter int DATA_W = 8,
   localparam int LD_W  = (WE_W > OE_W) ? WE_W : OE_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_we_tbl_i,
   input  logic              ld_oe_tbl_i,
   input  logic [STEP_W:0]   ld_addr_i,
   input  logic [LD_W-1:0]   ld_data_i,
   input  logic [DATA_W-1:0] bus_i,
   output logic [WE_W-1:0]   we_o,
   output logic [OE_W-1:0]   oe_o,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe_o
);
   generate
      if (OE_W < CB_MINW) begin : g_bad_oe
         $error("nor_useq: OE_W too narrow for control bits");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("nor_useq: STEP_W must be positive");
      end
   endgenerate

   useq_phase_e       phase;
   logic [STEP_W-1:0] step;
   logic              zflag;
   logic [WE_W-1:0]   we_word;
   logic [OE_W-1:0]   oe_word;
   logic              pulse, live;

   assign live  = ~rst_i;
   assign pulse = live & (phase == PH_PULSE);

   useq_phase #(.STEP_W(STEP_W)) u_phase (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .end_i   (oe_word[CB_END]),
      .phase_o (phase),
      .step_o  (step)
   );

   useq_table #(.AW(STEP_W), .DW(WE_W)) u_we_tbl (
      .clk_i     (clk_i),
      .wr_en_i   (ld_we_tbl_i),
      .wr_addr_i (ld_addr_i[STEP_W-1:0]),
      .wr_data_i (ld_data_i[WE_W-1:0]),
      .rd_addr_i (step),
      .rd_data_o (we_word)
   );

   useq_table #(.AW(STEP_W + 1), .DW(OE_W)) u_oe_tbl (
      .clk_i     (clk_i),
      .wr_en_i   (ld_oe_tbl_i),
      .wr_addr_i (ld_addr_i),
      .wr_data_i (ld_data_i[OE_W-1:0]),
      .rd_addr_i ({zflag, step}),
      .rd_data_o (oe_word)
   );

   useq_nor #(.DATA_W(DATA_W)) u_nor (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ld_a_i   (pulse & oe_word[CB_LDA]),
      .ld_b_i   (pulse & oe_word[CB_LDB]),
      .smp_i    (pulse),
      .drv_i    (live & oe_word[CB_DRV]),
      .bus_i    (bus_i),
      .bus_o    (bus_o),
      .bus_oe_o (bus_oe_o),
      .zflag_o  (zflag)
   );

   assign we_o = pulse ? we_word : '0;
   assign oe_o = live  ? oe_word : '0;
endmodule

// File: rtl/nor_useq_chk.sv
module nor_useq_chk
   import useq_pkg::*;
#(
   parameter int STEP_W = 4,
   parameter int WE_W   = 8,
   parameter int OE_W   = 8,
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_i,
   input useq_phase_e       phase,
   input logic [STEP_W-1:0] step,
   input logic              zflag,
   input logic [WE_W-1:0]   we_o,
   input logic [OE_W-1:0]   oe_o,
   input logic [DATA_W-1:0] bus_o,
   input logic              bus_oe_o
);
   localparam logic [STEP_W-1:0] ONE = 1;

   assert_we_pulse_only_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (we_o != '0) |-> (phase == PH_PULSE));

   assert_phase_toggles_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (phase != $past(phase)));

   assert_step_held_setup_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(phase) == PH_SETUP) |-> (step == $past(step)));

   assert_end_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_PULSE && oe_o[CB_END]) |=> (step == '0));

   assert_step_incr_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_PULSE && !oe_o[CB_END]) |=> (step == $past(step) + ONE));

   assert_drive_follows_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      bus_oe_o == oe_o[CB_DRV]);

   assert_detached_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      !bus_oe_o |-> (bus_o == '0));

   assert_flag_step_edge_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_SETUP) |=> $stable(zflag));

   always_comb begin
      if (rst_i) begin
         assert_reset_quiet_R8: assert ((we_o == '0) && (oe_o == '0) && !bus_oe_o);
      end
   end
endmodule

bind nor_useq nor_useq_chk #(
   .STEP_W(STEP_W), .WE_W(WE_W), .OE_W(OE_W), .DATA_W(DATA_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .phase    (phase),
   .step     (step),
   .zflag    (zflag),
   .we_o     (we_o),
   .oe_o     (oe_o),
   .bus_o    (bus_o),
   .bus_oe_o (bus_oe_o)
);

// File: tb/nor_useq_tb.sv
`timescale 1ns/1ps
module nor_useq_tb;
   localparam int NV = 31;
   // {step[4], bus_i[8], expected oe[8], expected bus_oe[4], expected bus_o[8]}
   localparam logic [31:0] VEC [NV] = '{
      32'h0_0F_02_0_00, 32'h1_30_14_0_00, 32'h2_00_28_1_C0, 32'h3_00_31_0_00,
      32'h0_F0_02_0_00, 32'h1_0F_14_0_00, 32'h2_00_28_1_00, 32'h3_00_C0_0_00,
      32'h4_00_B2_0_00, 32'h5_00_A8_1_F0, 32'h6_00_61_0_00,
      32'h0_0F_02_0_00, 32'h1_F0_14_0_00, 32'h2_00_28_1_00, 32'h3_00_C0_0_00,
      32'h4_FF_B2_0_00, 32'h5_00_A8_1_00, 32'h6_00_90_0_00, 32'h7_00_80_0_00,
      32'h8_00_70_0_00, 32'h9_00_60_0_00, 32'hA_00_50_0_00, 32'hB_00_40_0_00,
      32'hC_00_30_0_00, 32'hD_00_20_0_00, 32'hE_00_10_0_00, 32'hF_00_00_0_00,
      32'h0_00_F2_0_00, 32'h1_00_E0_0_00, 32'h2_00_28_1_0F, 32'h3_00_31_0_00
   };

   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       ld_we_tbl_i = 1'b0, ld_oe_tbl_i = 1'b0;
   logic [4:0] ld_addr_i = '0;
   logic [7:0] ld_data_i = '0, bus_i = '0;
   logic [7:0] we_o, oe_o, bus_o;
   logic       bus_oe_o;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   nor_useq u_dut (
      .clk_i(clk), .rst_i(rst_i), .ld_we_tbl_i(ld_we_tbl_i), .ld_oe_tbl_i(ld_oe_tbl_i),
      .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i), .bus_i(bus_i),
      .we_o(we_o), .oe_o(oe_o), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
   );

   function automatic logic [7:0] we_word(input int s);
      return 8'h50 | 8'(s);
   endfunction

   function automatic logic [7:0] ctl_word(input int a);
      logic [3:0] s;
      s = 4'(a);
      if (a < 16) begin
         case (a)
            0: return 8'h02;  1: return 8'h14;  2: return 8'h28;  3: return 8'h31;
            6: return 8'h61;
            default: return {s, 4'h0};
         endcase
      end else begin
         case (a - 16)
            0: return 8'hF2;  1: return 8'hE0;  3: return 8'hC0;  4: return 8'hB2;
            5: return 8'hA8;
            default: return {~s, 4'h0};
         endcase
      end
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic load(input bit tbl2, input int a, input logic [7:0] d);
      @(negedge clk);
      ld_we_tbl_i = !tbl2;
      ld_oe_tbl_i = tbl2;
      ld_addr_i   = 5'(a);
      ld_data_i   = d;
      @(negedge clk);
      ld_we_tbl_i = 1'b0;
      ld_oe_tbl_i = 1'b0;
   endtask

   initial begin
      #150000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R9: fill both tables while reset is held
      for (int s = 0; s < 16; s++) load(1'b0, s, we_word(s));
      for (int a = 0; a < 32; a++) load(1'b1, a, ctl_word(a));
      #1;
      // R8: outputs quiet in reset
      check("R8 we in reset", we_o, 8'h00);
      check("R8 oe in reset", oe_o, 8'h00);
      check("R8 bus_oe in reset", {7'b0, bus_oe_o}, 8'h00);
      @(negedge clk);
      rst_i = 1'b0;
      // R1 R2 R3 R4 R5 R6 R7 R10: microprogram walk, one vector per step
      for (int v = 0; v < NV; v++) begin
         logic [3:0] st;
         st    = VEC[v][31:28];
         bus_i = VEC[v][27:20];
         #1;
         check("R1 we zero in setup", we_o, 8'h00);
         check("R2/R3/R6/R7/R10 oe setup", oe_o, VEC[v][19:12]);
         check("R5 bus_oe", {7'b0, bus_oe_o}, {7'b0, VEC[v][8]});
         check("R4/R5 bus_o", bus_o, VEC[v][7:0]);
         @(negedge clk);
         #1;
         check("R1/R2 we in pulse", we_o, we_word(int'(st)));
         check("R2 oe pulse", oe_o, VEC[v][19:12]);
         @(negedge clk);
      end
      // R3: end bit in step 3 returned the counter to step 0
      #1;
      check("R3 back to step 0", oe_o, 8'h02);
      // R8/R9: reset mid-run, rewrite one first-table entry, restart
      rst_i = 1'b1;
      #1;
      check("R8 we mid-run reset", we_o, 8'h00);
      check("R8 oe mid-run reset", oe_o, 8'h00);
      load(1'b0, 0, 8'h3C);
      @(negedge clk);
      rst_i = 1'b0;
      bus_i = 8'h00;
      #1;
      check("R8 setup phase of step 0", we_o, 8'h00);
      check("R8 step 0 flag clear", oe_o, 8'h02);
      @(negedge clk);
      #1;
      check("R9 rewritten entry", we_o, 8'h3C);
      @(negedge clk);
      @(negedge clk);
      #1;
      check("R9 neighbour entry kept", we_o, 8'h51);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule